// File: doc/BRIEF.md
# Random Generator Control and Status Register Block

This block is the register front end of a hardware random number generator. A consumer reads four 32-bit result words, watches a ready flag, and acknowledges a result by writing 1 to that flag. The acknowledge releases the words and asks the generator for the next refill. A health-test unit reports faults as single-cycle pulses. Each fault latches a sticky status bit, and software clears it by writing 1. A per-fault enable in the control register decides whether that fault drives the interrupt line.

The block also holds the configuration that the generator reads: a global enable, a minimum and a maximum refill cycle count, and an alarm threshold. It reports a fixed revision word. The bus side is a plain single-cycle port: one write strobe, one read strobe, a byte address and registered read data.

Top module: `rngc_top`

## Requirements
- R1: After reset, every writable field, every status bit, `refill_req`, `irq` and `bus_rdata` are zero.
- R2: Control is at 0x14. Bit 10 is the generator enable and drives `gen_enable`. Bits 7..1 are the per-fault interrupt enables. All other bits read as zero.
- R3: Configuration is at 0x18, with the maximum refill count in bits 31:16 and the minimum refill count in bits 7:0. The alarm threshold is at 0x1C in bits 7:0. Unlisted bits read as zero, and the fields drive `refill_max`, `refill_min` and `alarm_thresh`.
- R4: The revision word at 0x7C reads as major in bits 27:24, minor in bits 23:20 and patch in bits 19:16, with every other bit zero. Writes to it have no effect.
- R5: Status is at 0x10. Bit 0 is ready. A pulse on `hlth_evt[k]` sets status bit k+1, whatever the interrupt enables hold. The fault bits are, from bit 1 to bit 7: shutdown overflow, stuck output, noise, run, long run, poker and monobit.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an event arrives in the same cycle as the clear of its bit, the bit stays set.
- R7: When `gen_valid` is high, the generator is enabled and ready is clear, ready sets on that edge. In the same edge `gen_data[32k+31:32k]` is captured into the word at byte offset 4k, for k = 0..3.
- R8: While ready is set, `gen_valid` is ignored and the four words keep their values.
- R9: `refill_req` is a one-cycle pulse in the cycle after either of two writes: a write of 1 to status bit 0 while ready is set, or a control write that turns the enable from 0 to 1.
- R10: While the generator is disabled, ready is clear, `gen_valid` is ignored and the four words read as zero. A control write that clears the enable also clears ready.
- R11: `irq` is high whenever ready is set or any fault bit k is set together with its control enable bit k (k = 1..7). It follows register state, so it changes in the cycle after the event.
- R12: `bus_rdata` updates only in the cycle after `bus_rd` and shows the state before that edge. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hlth_evt | input | 7 | Health-fault pulses, bit k sets status bit k+1 |
| gen_valid | input | 1 | New result strobe from the generator |
| gen_data | input | 128 | New result, word k in bits 32k+31:32k |
| gen_enable | output | 1 | Generator enable |
| refill_req | output | 1 | Request for the next result |
| irq | output | 1 | Interrupt |
| refill_max | output | 16 | Maximum refill cycles |
| refill_min | output | 8 | Minimum refill cycles |
| alarm_thresh | output | 8 | Alarm threshold |

## Verification
Every state change happens on the edge that samples its strobe. Status bits, words and `irq` therefore show the result one cycle after the stimulus, and `refill_req` is high for exactly that one cycle. Read data is due one cycle after `bus_rd` and reflects the state before that edge. A write and a read issued back to back therefore see the write. The bench drives inputs on the falling edge and updates its model on the rising edge. It compares every output on the next falling edge, which is exactly where each of those one-cycle latencies lands.

// File: rtl/rngc_pkg.sv
package rngc_pkg;
   localparam int unsigned OFS_WORD0 = 'h00;
   localparam int unsigned OFS_STAT  = 'h10;
   localparam int unsigned OFS_CTRL  = 'h14;
   localparam int unsigned OFS_CFG   = 'h18;
   localparam int unsigned OFS_ALARM = 'h1C;
   localparam int unsigned OFS_REV   = 'h7C;
   localparam int unsigned EN_BIT    = 10;
   localparam int unsigned READY_BIT = 0;
   localparam int unsigned MAXR_LSB  = 16;
   localparam int unsigned REVMAJ_LSB = 24;
   localparam int unsigned REVMIN_LSB = 20;
   localparam int unsigned REVPAT_LSB = 16;
endpackage

// File: rtl/rngc_ctrl_regs.sv
module rngc_ctrl_regs #(
   parameter int N_FAULT = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_ctrl,
   input  logic               wr_cfg,
   input  logic               wr_alarm,
   input  logic               wd_en,
   input  logic [N_FAULT-1:0] wd_fen,
   input  logic [15:0]        wd_max,
   input  logic [7:0]         wd_min,
   input  logic [7:0]         wd_alarm,
   output logic               gen_en,
   output logic [N_FAULT-1:0] fault_en,
   output logic [15:0]        max_refill,
   output logic [7:0]         min_refill,
   output logic [7:0]         alarm_th,
   output logic               en_rise,
   output logic               dis_now
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_en     <= 1'b0;
         fault_en   <= '0;
         max_refill <= '0;
         min_refill <= '0;
         alarm_th   <= '0;
      end else begin
         if (wr_ctrl) begin
            gen_en   <= wd_en;
            fault_en <= wd_fen;
         end
         if (wr_cfg) begin
            max_refill <= wd_max;
            min_refill <= wd_min;
         end
         if (wr_alarm) alarm_th <= wd_alarm;
      end
   end

   assign en_rise = wr_ctrl & wd_en & ~gen_en;
   assign dis_now = wr_ctrl & ~wd_en;
endmodule

// File: rtl/rngc_status.sv
module rngc_status #(
   parameter int N_FAULT = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_stat,
   input  logic [N_FAULT:0]   wclr,
   input  logic [N_FAULT-1:0] hlth_evt,
   input  logic               gen_valid,
   input  logic               gen_en,
   input  logic               dis_now,
   input  logic               en_rise,
   input  logic [N_FAULT-1:0] fault_en,
   output logic               ready,
   output logic [N_FAULT-1:0] faults,
   output logic               capture,
   output logic               refill_req,
   output logic               irq
);
   logic ack_clr;
   logic ack_pulse;

   assign capture   = gen_valid & gen_en & ~ready;
   assign ack_clr   = wr_stat & wclr[0];
   assign ack_pulse = ack_clr & ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready      <= 1'b0;
         refill_req <= 1'b0;
      end else begin
         if (dis_now) ready <= 1'b0;
         else         ready <= (ready & ~ack_clr) | capture;
         refill_req <= ack_pulse | en_rise;
      end
   end

   // one sticky cell per health fault, set has priority over clear
   for (genvar k = 0; k < N_FAULT; k++) begin : g_fault
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  faults[k] <= 1'b0;
         else if (hlth_evt[k])        faults[k] <= 1'b1;
         else if (wr_stat & wclr[k+1]) faults[k] <= 1'b0;
      end
   end

   assign irq = ready | (|(faults & fault_en));
endmodule

// File: rtl/rngc_words.sv
module rngc_words #(
   parameter int N_WORDS = 4,
   parameter int DATA_W  = 32,
   localparam int FLAT_W = N_WORDS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [FLAT_W-1:0] gen_data,
   output logic [FLAT_W-1:0] words
);
   for (genvar k = 0; k < N_WORDS; k++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       words[k*DATA_W +: DATA_W] <= '0;
         else if (capture) words[k*DATA_W +: DATA_W] <= gen_data[k*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/rngc_rdmux.sv
module rngc_rdmux #(
   parameter int         ADDR_W    = 7,
   parameter int         DATA_W    = 32,
   parameter int         N_WORDS   = 4,
   parameter int         N_FAULT   = 7,
   parameter bit         RDATA_REG = 1'b1,
   parameter logic [3:0] REV_MAJOR = 4'h3,
   parameter logic [3:0] REV_MINOR = 4'h1,
   parameter logic [3:0] REV_PATCH = 4'h2,
   localparam int FLAT_W = N_WORDS * DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [FLAT_W-1:0]  words,
   input  logic               gen_en,
   input  logic [N_FAULT-1:0] fault_en,
   input  logic               ready,
   input  logic [N_FAULT-1:0] faults,
   input  logic [15:0]        max_refill,
   input  logic [7:0]         min_refill,
   input  logic [7:0]         alarm_th,
   output logic [DATA_W-1:0]  rdata
);
   import rngc_pkg::*;

   logic [DATA_W-1:0] mux;

   always_comb begin
      mux = '0;
      if (addr == ADDR_W'(OFS_STAT)) begin
         mux[N_FAULT:0] = {faults, ready};
      end else if (addr == ADDR_W'(OFS_CTRL)) begin
         mux[EN_BIT]    = gen_en;
         mux[N_FAULT:1] = fault_en;
      end else if (addr == ADDR_W'(OFS_CFG)) begin
         mux[MAXR_LSB +: 16] = max_refill;
         mux[7:0]            = min_refill;
      end else if (addr == ADDR_W'(OFS_ALARM)) begin
         mux[7:0] = alarm_th;
      end else if (addr == ADDR_W'(OFS_REV)) begin
         mux[REVMAJ_LSB +: 4] = REV_MAJOR;
         mux[REVMIN_LSB +: 4] = REV_MINOR;
         mux[REVPAT_LSB +: 4] = REV_PATCH;
      end else begin
         for (int k = 0; k < N_WORDS; k++) begin
            if (gen_en && addr == ADDR_W'(OFS_WORD0 + 4 * k))
               mux = words[k*DATA_W +: DATA_W];
         end
      end
   end

   if (RDATA_REG) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  rdata <= '0;
         else if (rd) rdata <= mux;
      end
   end else begin : g_rd_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign rdata = rd ? mux : '0;
   end
endmodule

// File: rtl/rngc_top.sv
module rngc_top #(
   parameter int         ADDR_W    = 7,
   parameter int         DATA_W    = 32,
   parameter int         N_WORDS   = 4,
   parameter int         N_FAULT   = 7,
   parameter bit         RDATA_REG = 1'b1,
   parameter logic [3:0] REV_MAJOR = 4'h3,
   parameter logic [3:0] REV_MINOR = 4'h1,
   parameter logic [3:0] REV_PATCH = 4'h2,
   localparam int FLAT_W = N_WORDS * DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [N_FAULT-1:0] hlth_evt,
   input  logic               gen_valid,
   input  logic [FLAT_W-1:0]  gen_data,
   output logic               gen_enable,
   output logic               refill_req,
   output logic               irq,
   output logic [15:0]        refill_max,
   output logic [7:0]         refill_min,
   output logic [7:0]         alarm_thresh
);
   import rngc_pkg::*;

   if (DATA_W != 32) begin : g_chk_dw
      $error("rngc_top: DATA_W must be 32");
   end
   if (ADDR_W < 7) begin : g_chk_aw
      $error("rngc_top: ADDR_W must reach offset 0x7C");
   end
   if (N_WORDS < 1 || N_WORDS > 4) begin : g_chk_nw
      $error("rngc_top: N_WORDS must lie in 1..4");
   end
   if (N_FAULT < 1 || N_FAULT > 7) begin : g_chk_nf
      $error("rngc_top: N_FAULT must lie in 1..7");
   end

   logic wr_stat, wr_ctrl, wr_cfg, wr_alarm;
   logic en_rise_w, dis_now_w, capture_w, ready_w;
   logic [N_FAULT-1:0] fault_en_w, faults_w;
   logic [FLAT_W-1:0]  words_flat;
   logic unused_wbits;

   assign wr_stat  = bus_wr & (bus_addr == ADDR_W'(OFS_STAT));
   assign wr_ctrl  = bus_wr & (bus_addr == ADDR_W'(OFS_CTRL));
   assign wr_cfg   = bus_wr & (bus_addr == ADDR_W'(OFS_CFG));
   assign wr_alarm = bus_wr & (bus_addr == ADDR_W'(OFS_ALARM));
   assign unused_wbits = ^bus_wdata;

   rngc_ctrl_regs #(.N_FAULT(N_FAULT)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ctrl    (wr_ctrl),
      .wr_cfg     (wr_cfg),
      .wr_alarm   (wr_alarm),
      .wd_en      (bus_wdata[EN_BIT]),
      .wd_fen     (bus_wdata[N_FAULT:1]),
      .wd_max     (bus_wdata[MAXR_LSB +: 16]),
      .wd_min     (bus_wdata[7:0]),
      .wd_alarm   (bus_wdata[7:0]),
      .gen_en     (gen_enable),
      .fault_en   (fault_en_w),
      .max_refill (refill_max),
      .min_refill (refill_min),
      .alarm_th   (alarm_thresh),
      .en_rise    (en_rise_w),
      .dis_now    (dis_now_w)
   );

   rngc_status #(.N_FAULT(N_FAULT)) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_stat    (wr_stat),
      .wclr       (bus_wdata[N_FAULT:0]),
      .hlth_evt   (hlth_evt),
      .gen_valid  (gen_valid),
      .gen_en     (gen_enable),
      .dis_now    (dis_now_w),
      .en_rise    (en_rise_w),
      .fault_en   (fault_en_w),
      .ready      (ready_w),
      .faults     (faults_w),
      .capture    (capture_w),
      .refill_req (refill_req),
      .irq        (irq)
   );

   rngc_words #(.N_WORDS(N_WORDS), .DATA_W(DATA_W)) u_words (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (capture_w),
      .gen_data (gen_data),
      .words    (words_flat)
   );

   rngc_rdmux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_WORDS(N_WORDS), .N_FAULT(N_FAULT),
      .RDATA_REG(RDATA_REG), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR),
      .REV_PATCH(REV_PATCH)
   ) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd         (bus_rd),
      .addr       (bus_addr),
      .words      (words_flat),
      .gen_en     (gen_enable),
      .fault_en   (fault_en_w),
      .ready      (ready_w),
      .faults     (faults_w),
      .max_refill (refill_max),
      .min_refill (refill_min),
      .alarm_th   (alarm_thresh),
      .rdata      (bus_rdata)
   );
endmodule

// File: rtl/rngc_sva.sv
module rngc_sva #(
   parameter int W  = 128,
   parameter int NF = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          gen_en,
   input logic          ready,
   input logic [W-1:0]  words,
   input logic [NF-1:0] evt,
   input logic [NF-1:0] fen,
   input logic [NF-1:0] faults,
   input logic          irq,
   input logic          refill,
   input logic          ack_wr,
   input logic          ctrl_wr
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_ready_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && ready && !$past(ready)) |-> $past(gen_en));

   assert_words_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && ready && $past(ready)) |-> $stable(words));

   assert_evt_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((faults & $past(evt)) == $past(evt)));

   assert_ack_refill_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && ready) |=> (!ready && refill));

   assert_refill_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      refill |=> !refill);

   assert_off_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en |-> !ready);

   assert_ready_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> irq);

   assert_evt_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(evt & fen)) && !ctrl_wr) |=> irq);
endmodule

bind rngc_top rngc_sva #(.W(N_WORDS * DATA_W), .NF(N_FAULT)) u_sva (
   .clk     (clk),
   .rst_n   (rst_n),
   .gen_en  (gen_enable),
   .ready   (ready_w),
   .words   (words_flat),
   .evt     (hlth_evt),
   .fen     (fault_en_w),
   .faults  (faults_w),
   .irq     (irq),
   .refill  (refill_req),
   .ack_wr  (bus_wr && (bus_addr == ADDR_W'(rngc_pkg::OFS_STAT)) && bus_wdata[0]),
   .ctrl_wr (bus_wr && (bus_addr == ADDR_W'(rngc_pkg::OFS_CTRL)))
);

// File: tb/rngc_top_tb.sv
`timescale 1ns/1ps
module rngc_top_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0, bus_rd = 1'b0;
   logic [6:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [6:0]   hlth_evt = '0;
   logic         gen_valid = 1'b0;
   logic [127:0] gen_data = '0;
   logic         gen_enable, refill_req, irq;
   logic [15:0]  refill_max;
   logic [7:0]   refill_min, alarm_thresh;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   rngc_top u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .hlth_evt(hlth_evt), .gen_valid(gen_valid), .gen_data(gen_data),
      .gen_enable(gen_enable), .refill_req(refill_req), .irq(irq),
      .refill_max(refill_max), .refill_min(refill_min), .alarm_thresh(alarm_thresh)
   );

   // ---------------- behavioural reference model ----------------
   bit [31:0] m_words [4];
   bit        m_en;
   bit [6:0]  m_fen;
   bit [15:0] m_max;
   bit [7:0]  m_min, m_alarm, m_st;
   bit        m_refill;
   bit [31:0] m_rdata;
   bit        m_rd_pending;
   bit [6:0]  m_rd_addr;

   function automatic bit [31:0] model_read(bit [6:0] a);
      case (a)
         7'h00, 7'h04, 7'h08, 7'h0C: return m_en ? m_words[a[3:2]] : 32'h0;
         7'h10: return {24'h0, m_st};
         7'h14: return {21'h0, m_en, 2'b00, m_fen, 1'b0};
         7'h18: return {m_max, 8'h0, m_min};
         7'h1C: return {24'h0, m_alarm};
         7'h7C: return 32'h0312_0000;
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit model_irq();
      return m_st[0] | (|(m_st[7:1] & m_fen));
   endfunction

   function automatic string tag_of(bit [6:0] a);
      case (a)
         7'h00, 7'h04, 7'h08, 7'h0C: return "R7";
         7'h10: return "R6";
         7'h14: return "R2";
         7'h18, 7'h1C: return "R3";
         7'h7C: return "R4";
         default: return "R12";
      endcase
   endfunction

   always @(posedge clk) begin
      bit [7:0] st;
      bit       en_n;
      if (!rst_n) begin
         foreach (m_words[k]) m_words[k] = '0;
         m_en = 0; m_fen = 0; m_max = 0; m_min = 0; m_alarm = 0; m_st = 0;
         m_refill = 0; m_rdata = 0; m_rd_pending = 0;
      end else begin
         m_rd_pending = bus_rd;
         if (bus_rd) begin
            m_rdata   = model_read(bus_addr);
            m_rd_addr = bus_addr;
         end
         st = m_st; en_n = m_en; m_refill = 0;
         if (bus_wr) begin
            case (bus_addr)
               7'h10: begin
                  if (bus_wdata[0] && m_st[0]) m_refill = 1;
                  st = st & ~bus_wdata[7:0];
               end
               7'h14: begin
                  if (bus_wdata[10] && !m_en) m_refill = 1;
                  en_n  = bus_wdata[10];
                  m_fen = bus_wdata[7:1];
               end
               7'h18: begin m_max = bus_wdata[31:16]; m_min = bus_wdata[7:0]; end
               7'h1C: m_alarm = bus_wdata[7:0];
               default: ;
            endcase
         end
         st[7:1] = st[7:1] | hlth_evt;
         if (gen_valid && m_en && !m_st[0]) begin
            st[0] = 1;
            for (int k = 0; k < 4; k++) m_words[k] = gen_data[32*k +: 32];
         end
         if (!en_n) st[0] = 0;
         m_st = st; m_en = en_n;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the rising edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk(irq === model_irq(), "R11 irq", {31'h0, irq}, {31'h0, model_irq()});
         chk(refill_req === m_refill, "R9 refill_req", {31'h0, refill_req}, {31'h0, m_refill});
         chk(gen_enable === m_en, "R2 gen_enable", {31'h0, gen_enable}, {31'h0, m_en});
         chk({refill_max, refill_min, alarm_thresh} === {m_max, m_min, m_alarm}, "R3 cfg outputs",
             {refill_max, refill_min, 8'h0}, {m_max, m_min, 8'h0});
         if (m_rd_pending)
            chk(bus_rdata === m_rdata, tag_of(m_rd_addr), bus_rdata, m_rdata);
      end
   end

   // ---------------- stimulus helpers (entered at a falling edge) ----------------
   task automatic do_write(input bit [6:0] a, input bit [31:0] d);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic expect_rd(input bit [6:0] a, input bit [31:0] exp, input string req);
      bus_rd = 1; bus_addr = a;
      @(negedge clk);
      bus_rd = 0;
      chk(bus_rdata === exp, req, bus_rdata, exp);
   endtask

   task automatic gen_pulse(input bit [127:0] d);
      gen_valid = 1; gen_data = d;
      @(negedge clk);
      gen_valid = 0;
   endtask

   task automatic evt_pulse(input bit [6:0] e);
      hlth_evt = e;
      @(negedge clk);
      hlth_evt = 0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(irq === 1'b0 && refill_req === 1'b0 && gen_enable === 1'b0, "R1 outputs",
          {29'h0, irq, refill_req, gen_enable}, 32'h0);
      chk(bus_rdata === 32'h0, "R1 rdata", bus_rdata, 32'h0);
      expect_rd(7'h10, 32'h0, "R1 status");
      expect_rd(7'h14, 32'h0, "R1 control");
      expect_rd(7'h18, 32'h0, "R1 config");

      // R4 revision, read-only
      expect_rd(7'h7C, 32'h0312_0000, "R4 revision");
      do_write(7'h7C, 32'hFFFF_FFFF);
      expect_rd(7'h7C, 32'h0312_0000, "R4 revision after write");

      // R3 configuration and alarm threshold
      do_write(7'h18, 32'hFFFF_FFFF);
      expect_rd(7'h18, 32'hFFFF_00FF, "R3 config");
      chk(refill_max === 16'hFFFF && refill_min === 8'hFF, "R3 refill pins",
          {refill_max, refill_min, 8'h0}, 32'hFFFF_FF00);
      do_write(7'h1C, 32'h0000_1234);
      expect_rd(7'h1C, 32'h0000_0034, "R3 alarm");

      // R10 disabled: strobe ignored, words zero
      gen_pulse({32'h9, 32'h8, 32'h7, 32'h6});
      expect_rd(7'h10, 32'h0, "R10 no ready when off");
      expect_rd(7'h04, 32'h0, "R10 word reads zero");

      // R2 control; enable rising pulses refill (R9)
      do_write(7'h14, 32'hFFFF_FFFF);
      chk(refill_req === 1'b1, "R9 refill on enable", {31'h0, refill_req}, 32'h1);
      expect_rd(7'h14, 32'h0000_04FE, "R2 control bits");
      do_write(7'h14, 32'h0000_0400);

      // R7 capture
      gen_pulse({32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111});
      chk(irq === 1'b1, "R11 irq on ready", {31'h0, irq}, 32'h1);
      expect_rd(7'h10, 32'h1, "R7 ready set");
      expect_rd(7'h00, 32'h1111_1111, "R7 word0");
      expect_rd(7'h0C, 32'h4444_4444, "R7 word3");

      // R8 strobe ignored while ready
      gen_pulse({4{32'hAAAA_AAAA}});
      expect_rd(7'h00, 32'h1111_1111, "R8 word0 held");
      expect_rd(7'h08, 32'h3333_3333, "R8 word2 held");

      // R6 write 0 leaves ready; R9 ack clears and pulses refill
      do_write(7'h10, 32'h0000_00FE);
      expect_rd(7'h10, 32'h1, "R6 zero bit kept");
      do_write(7'h10, 32'h0000_0001);
      chk(refill_req === 1'b1, "R9 refill on ack", {31'h0, refill_req}, 32'h1);
      @(negedge clk);
      chk(refill_req === 1'b0, "R9 refill one cycle", {31'h0, refill_req}, 32'h0);
      expect_rd(7'h10, 32'h0, "R9 ready cleared");

      // R5 faults, R11 masking
      evt_pulse(7'h01);
      expect_rd(7'h10, 32'h2, "R5 shutdown bit");
      chk(irq === 1'b0, "R11 masked fault", {31'h0, irq}, 32'h0);
      do_write(7'h14, 32'h0000_0402);
      chk(irq === 1'b1, "R11 enabled fault", {31'h0, irq}, 32'h1);
      evt_pulse(7'h7F);
      expect_rd(7'h10, 32'hFE, "R5 all faults");
      do_write(7'h10, 32'h0000_000C);
      expect_rd(7'h10, 32'hF2, "R6 partial clear");
      hlth_evt = 7'h02; bus_wr = 1; bus_addr = 7'h10; bus_wdata = 32'h4;
      @(negedge clk);
      hlth_evt = 0; bus_wr = 0;
      expect_rd(7'h10, 32'hF6, "R6 set beats clear");
      do_write(7'h10, 32'h0000_00FF);
      expect_rd(7'h10, 32'h0, "R6 clear all");

      // R10 disable drops ready, words masked then restored
      gen_pulse({32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000});
      do_write(7'h14, 32'h0);
      expect_rd(7'h10, 32'h0, "R10 disable clears ready");
      expect_rd(7'h00, 32'h0, "R10 words masked");
      do_write(7'h14, 32'h0000_0400);
      expect_rd(7'h00, 32'hAAAA_0000, "R10 words retained");

      // R12 unmapped
      expect_rd(7'h40, 32'h0, "R12 unmapped");
      expect_rd(7'h20, 32'h0, "R12 hole");

      // random traffic compared against the model every cycle
      for (int i = 0; i < 600; i++) begin
         int op;
         bit [6:0] adrs [7];
         adrs = '{7'h00, 7'h04, 7'h0C, 7'h10, 7'h14, 7'h18, 7'h1C};
         op = $urandom_range(0, 9);
         hlth_evt  = ($urandom_range(0, 7) == 0) ? 7'($urandom) : 7'h0;
         gen_valid = ($urandom_range(0, 2) == 0);
         gen_data  = {$urandom, $urandom, $urandom, $urandom};
         bus_addr  = adrs[$urandom_range(0, 6)];
         bus_wdata = $urandom;
         if (bus_addr == 7'h14 && $urandom_range(0, 4) != 0) bus_wdata[10] = 1'b1;
         bus_wr = (op < 3);
         bus_rd = (op >= 3 && op < 7);
         @(negedge clk);
      end
      bus_wr = 0; bus_rd = 0; hlth_evt = 0; gen_valid = 0;
      @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule